// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block controls reset for a configuration controller. After the supply comes up it keeps the controller in reset for a delay. A pin picks the length of that delay: 2 ms or 100 ms, counted in clock cycles. While the delay runs, the block pulls a shared open-drain output-enable line low. When the delay ends it lets go of the line. The system stays in reset until the line actually reads high, so any external device that keeps the line low also stretches the reset. The flash reset is released one cycle before the line is let go.

Once the block is running, three events send it back. A drop of the supply-good input restarts the full power-up delay. A low target status line starts a reconfiguration. A controller error also starts a reconfiguration when auto-restart is on; when auto-restart is off, the error only raises a flag. A reconfiguration drives the line low for a fixed minimum pulse and then waits for the line to read high again. A separate output keeps test-port and programming commands blocked until the first power-up sequence has finished.

Top module: `rst_seq_top`

## Requirements
- R1: While `supply_ok` is low, `oe_drive_low`, `sys_rst`, `flash_rst` and `prog_block` are 1 and `err_flag` is 0.
- R2: The power-up delay is sampled from `fast_sel` only while `supply_ok` is low. With `fast_sel`=1 the delay is 2*CLK_PER_MS cycles, otherwise 100*CLK_PER_MS cycles. `oe_drive_low` falls after exactly that many rising edges with `supply_ok` high. A change on `fast_sel` after `supply_ok` rises has no effect on the delay.
- R3: `flash_rst` stays 1 through the delay and falls exactly one cycle before `oe_drive_low` falls at the end of the power-up delay.
- R4: After the line is released, `sys_rst` stays 1 while `oe_line_in` reads low. It falls on the third rising edge after `oe_line_in` reads high, because the line passes through a two-flop synchronizer.
- R5: A low `supply_ok` at a rising edge returns every output to its R1 state on that edge.
- R6: When `tgt_status_n` goes low while running, `oe_drive_low` rises on the third rising edge, after the two-flop synchronizer.
- R7: A reconfiguration holds `oe_drive_low` at 1 for exactly PULSE_CYC cycles. The block then releases the line and follows R4 before it runs again.
- R8: A `ctrl_err` of 1 while running with `auto_restart_en`=1 raises `oe_drive_low` on the next rising edge.
- R9: A `ctrl_err` of 1 while running with `auto_restart_en`=0 sets `err_flag` on the next edge and leaves `oe_drive_low` and `sys_rst` at 0. The flag clears on the edge that starts the next reconfiguration.
- R10: `prog_block` stays 1 until the first time `sys_rst` falls after power-up. It then stays 0 through reconfigurations until `supply_ok` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| supply_ok | input | 1 | Supply-good indication; low acts as synchronous reset |
| fast_sel | input | 1 | 1 selects the short power-up delay |
| oe_line_in | input | 1 | Sampled level of the shared open-drain output-enable line |
| tgt_status_n | input | 1 | Target status line, low requests reconfiguration |
| ctrl_err | input | 1 | Controller-detected error, synchronous to clk |
| auto_restart_en | input | 1 | Option bit: an error starts reconfiguration |
| oe_drive_low | output | 1 | 1 pulls the output-enable line low |
| sys_rst | output | 1 | Internal system reset, active high |
| flash_rst | output | 1 | Flash reset, active high |
| prog_block | output | 1 | 1 blocks test-port and programming commands |
| err_flag | output | 1 | Reported error when auto-restart is off |

## Verification
The bench checks both delay lengths to the exact cycle, and includes a delay-select change made after power-up. A design that sampled the pin live would release the line 20 cycles into a 1000-cycle delay. It checks the one-cycle gap between flash release and line release; an off-by-one counter would release both on the same cycle. It holds the line low externally to show that the reset stretches, and counts the synchronizer latency on the status line and on the line read-back; a design missing a flop would respond a cycle early. Random status pulses and errors, with auto-restart randomly on or off, check the reconfiguration pulse width, that errors without auto-restart only set the flag, and that the command block stays clear across reconfigurations.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_POR    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_RUN    = 2'd2,
        ST_RECONF = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic oe_low;
        logic sys_rst;
        logic flash_rst;
    } drive_s;

    function automatic int unsigned delay_cycles(input int unsigned per_ms,
                                                 input int unsigned ms);
        return per_ms * ms;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int unsigned W = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 200000,
    parameter int unsigned FAST_MS    = 2,
    parameter int unsigned SLOW_MS    = 100,
    parameter int unsigned PULSE_CYC  = 16
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic fast_sel,
    input  logic oe_line_in,
    input  logic tgt_status_n,
    input  logic ctrl_err,
    input  logic auto_restart_en,
    output logic oe_drive_low,
    output logic sys_rst,
    output logic flash_rst,
    output logic prog_block,
    output logic err_flag
);
    localparam int unsigned FAST_CYC = delay_cycles(CLK_PER_MS, FAST_MS);
    localparam int unsigned SLOW_CYC = delay_cycles(CLK_PER_MS, SLOW_MS);
    localparam int unsigned CNT_W    = $clog2(umax(umax(SLOW_CYC, FAST_CYC), PULSE_CYC) + 1);
    localparam logic [CNT_W-1:0] FAST_LAST  = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST  = CNT_W'(SLOW_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

    logic             rst;
    logic [1:0]       sync_q;
    logic             oe_s;
    logic             stat_s;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             sel_fast;
    logic             por_done;
    logic             delay_last;
    logic             err_restart;
    seq_state_e       state, state_nx;
    drive_s           drv;

    assign rst = !supply_ok;

    rst_seq_sync #(
        .W       (2),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({tgt_status_n, oe_line_in}),
        .q   (sync_q)
    );
    assign oe_s   = sync_q[0];
    assign stat_s = sync_q[1];

    rst_seq_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    assign delay_last  = (cnt == (sel_fast ? FAST_LAST : SLOW_LAST));
    assign err_restart = ctrl_err && auto_restart_en;
    assign cnt_clr     = (state_nx != state);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POR:    if (delay_last) state_nx = ST_WAIT;
            ST_WAIT:   if (oe_s) state_nx = ST_RUN;
            ST_RUN:    if (!stat_s || err_restart) state_nx = ST_RECONF;
            ST_RECONF: if (cnt == PULSE_LAST) state_nx = ST_WAIT;
            default:   state_nx = ST_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_POR;
            sel_fast <= fast_sel;
            por_done <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_RUN) begin
                por_done <= 1'b1;
            end
            if (state_nx == ST_RECONF && state != ST_RECONF) begin
                err_flag <= 1'b0;
            end else if (state == ST_RUN && ctrl_err && !auto_restart_en) begin
                err_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        drv.oe_low    = (state == ST_POR) || (state == ST_RECONF);
        drv.sys_rst   = (state != ST_RUN);
        drv.flash_rst = (state == ST_POR) && (cnt != (sel_fast ? FAST_LAST : SLOW_LAST));
    end

    assign oe_drive_low = drv.oe_low;
    assign sys_rst      = drv.sys_rst;
    assign flash_rst    = drv.flash_rst;
    assign prog_block   = !por_done;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int unsigned PULSE_CYC = 16
) (
    input logic clk,
    input logic supply_ok,
    input logic ctrl_err,
    input logic auto_restart_en,
    input logic oe_drive_low,
    input logic sys_rst,
    input logic flash_rst,
    input logic prog_block,
    input logic err_flag
);
    localparam int unsigned LW = $clog2(PULSE_CYC + 2) + 1;
    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!supply_ok) begin
            run_len <= '0;
        end else if (oe_drive_low) begin
            if (run_len != '1) run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_FLASH_FIRST: assert property (@(posedge clk) disable iff (!supply_ok)
        ($fell(oe_drive_low) && prog_block) |-> $past(!flash_rst)); // R3
    AST_FLASH_IN_DELAY: assert property (@(posedge clk) disable iff (!supply_ok)
        flash_rst |-> (oe_drive_low && prog_block)); // R3
    AST_RUN_RELEASED: assert property (@(posedge clk) disable iff (!supply_ok)
        !sys_rst |-> !oe_drive_low); // R4
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!supply_ok)
        ($fell(oe_drive_low) && !prog_block) |-> (run_len == LW'(PULSE_CYC))); // R7
    AST_ERR_REPORT: assert property (@(posedge clk) disable iff (!supply_ok)
        (ctrl_err && !auto_restart_en && !sys_rst) |=> err_flag); // R9
    AST_BLOCK_STICKY: assert property (@(posedge clk) disable iff (!supply_ok)
        !prog_block |=> !prog_block); // R10
endmodule

bind rst_seq_top rst_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk             (clk),
    .supply_ok       (supply_ok),
    .ctrl_err        (ctrl_err),
    .auto_restart_en (auto_restart_en),
    .oe_drive_low    (oe_drive_low),
    .sys_rst         (sys_rst),
    .flash_rst       (flash_rst),
    .prog_block      (prog_block),
    .err_flag        (err_flag)
);

// File: tb/rst_seq_top_bench.sv
`timescale 1ns/1ps
module rst_seq_top_bench;
    localparam int unsigned PER_MS = 10;
    localparam int unsigned PULSE  = 8;
    localparam int unsigned FAST_D = 2 * PER_MS;
    localparam int unsigned SLOW_D = 100 * PER_MS;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic fast_sel = 1'b1;
    logic ext_hold = 1'b0;
    logic tgt_status_n = 1'b1;
    logic ctrl_err = 1'b0;
    logic auto_restart_en = 1'b0;
    logic oe_line_in;
    logic oe_drive_low, sys_rst, flash_rst, prog_block, err_flag;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    assign oe_line_in = !oe_drive_low && !ext_hold;

    rst_seq_top #(
        .CLK_PER_MS (PER_MS),
        .PULSE_CYC  (PULSE)
    ) u_rst_seq_top (
        .clk             (clk),
        .supply_ok       (supply_ok),
        .fast_sel        (fast_sel),
        .oe_line_in      (oe_line_in),
        .tgt_status_n    (tgt_status_n),
        .ctrl_err        (ctrl_err),
        .auto_restart_en (auto_restart_en),
        .oe_drive_low    (oe_drive_low),
        .sys_rst         (sys_rst),
        .flash_rst       (flash_rst),
        .prog_block      (prog_block),
        .err_flag        (err_flag)
    );

    function automatic int trig_latency(input int kind);
        return (kind == 0) ? 3 : 1;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic measure_pulse(output int len);
        len = 0;
        while (oe_drive_low && len < 100) begin
            len++;
            step(1);
        end
    endtask

    task automatic finish_run(input string req);
        step(2);
        chk({req, " sys_rst held during sync"}, sys_rst, 1'b1);
        step(1);
        chk({req, " sys_rst released"}, sys_rst, 1'b0);
    endtask

    initial begin
        int len;
        void'($urandom(32'h5EED));
        step(3);
        // R1 reset state
        chk("R1 oe", oe_drive_low, 1'b1);
        chk("R1 sys", sys_rst, 1'b1);
        chk("R1 flash", flash_rst, 1'b1);
        chk("R1 block", prog_block, 1'b1);
        chk("R1 err", err_flag, 1'b0);

        // R2 R3 fast delay
        supply_ok = 1'b1;
        step(FAST_D - 2);
        chk("R3 flash before end", flash_rst, 1'b1);
        chk("R2 oe before end", oe_drive_low, 1'b1);
        step(1);
        chk("R3 flash early fall", flash_rst, 1'b0);
        chk("R3 oe still low", oe_drive_low, 1'b1);
        step(1);
        chk("R2 fast release", oe_drive_low, 1'b0);
        chk("R10 block before run", prog_block, 1'b1);
        finish_run("R4");
        chk("R10 block cleared", prog_block, 1'b0);

        // R5 supply drop
        supply_ok = 1'b0;
        step(1);
        chk("R5 oe", oe_drive_low, 1'b1);
        chk("R5 sys", sys_rst, 1'b1);
        chk("R5 flash", flash_rst, 1'b1);
        chk("R5 block", prog_block, 1'b1);
        fast_sel = 1'b0;
        step(2);

        // R2 slow delay, late select change ignored, R4 external hold
        supply_ok = 1'b1;
        ext_hold = 1'b1;
        step(1);
        fast_sel = 1'b1;
        step(SLOW_D - 3);
        chk("R2 slow not early", oe_drive_low, 1'b1);
        chk("R3 slow flash on", flash_rst, 1'b1);
        step(1);
        chk("R3 slow flash fall", flash_rst, 1'b0);
        step(1);
        chk("R2 slow release", oe_drive_low, 1'b0);
        step(20);
        chk("R4 held by line", sys_rst, 1'b1);
        ext_hold = 1'b0;
        finish_run("R4 after hold");

        // R9 error without auto-restart
        auto_restart_en = 1'b0;
        ctrl_err = 1'b1;
        step(1);
        ctrl_err = 1'b0;
        chk("R9 flag", err_flag, 1'b1);
        chk("R9 no drive", oe_drive_low, 1'b0);
        chk("R9 no reset", sys_rst, 1'b0);

        // R6 status low
        tgt_status_n = 1'b0;
        step(2);
        chk("R6 not yet", oe_drive_low, 1'b0);
        step(1);
        tgt_status_n = 1'b1;
        chk("R6 drive", oe_drive_low, 1'b1);
        chk("R9 flag cleared", err_flag, 1'b0);
        chk("R10 stays clear", prog_block, 1'b0);
        measure_pulse(len);
        chk_int("R7 pulse width", len, PULSE);
        finish_run("R7");

        // R8 error with auto-restart
        auto_restart_en = 1'b1;
        ctrl_err = 1'b1;
        step(1);
        ctrl_err = 1'b0;
        chk("R8 drive", oe_drive_low, 1'b1);
        measure_pulse(len);
        chk_int("R8 R7 pulse width", len, PULSE);
        finish_run("R8");

        // random mix
        for (int i = 0; i < 24; i++) begin
            int kind;
            int lat;
            kind = $urandom % 3;
            lat = trig_latency(kind);
            step($urandom % 5);
            if (kind == 0) begin
                auto_restart_en = $urandom % 2;
                tgt_status_n = 1'b0;
            end else begin
                auto_restart_en = (kind == 1);
                ctrl_err = 1'b1;
            end
            if (lat > 1) step(lat - 1);
            chk("R6 R8 no early drive", oe_drive_low, 1'b0);
            step(1);
            ctrl_err = 1'b0;
            tgt_status_n = 1'b1;
            if (kind == 2) begin
                chk("R9 rand flag", err_flag, 1'b1);
                chk("R9 rand no drive", oe_drive_low, 1'b0);
            end else begin
                chk("R6 R8 rand drive", oe_drive_low, 1'b1);
                chk("R9 rand flag clear", err_flag, 1'b0);
                measure_pulse(len);
                chk_int("R7 rand pulse", len, PULSE);
                finish_run("R7 rand");
                chk("R10 rand block", prog_block, 1'b0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule